// File: doc/BRIEF.md
# Transceiver Control Register Bank with Self-Clearing Calibration

This block is the register file of a radio transceiver front end. A host reaches it through a plain bus with an address, a write strobe, write data and read data. The bank holds four writable registers: power configuration, control, mode configuration and timing configuration. It also has one read-only status word that reports live conditions from the analog side.

Two calibration engines sit outside the block. Software starts a calibration by writing 1 to its request bit in the control register. The bank then sends a one-cycle start pulse to the engine and holds the request bit at 1 until the engine answers with a done pulse. At that point the request bit drops back to 0 and the matching done flag in the status word is set.

The FSK calibration can also start by itself. This happens when the block leaves sleep while discontinuous receive and automatic calibration are both enabled. The bank also merges its register bits with two external pins to form the effective sleep and transmit controls.

Top module: `xcvr_regbank`

## Requirements
- R1: After reset the power, control, mode and timing registers read 0x00, both done flags read 0, and no start pulse is issued.
- R2: Writable registers are read back through a combinational read path:
  - address 0x00 (power) holds bits 7..1, and bit 0 reads 0;
  - address 0x02 (mode) holds all 8 bits;
  - address 0x03 (timing) holds bits 6..0, and bit 7 reads 0;
  - address 0x01 (control) holds bits 7, 6, 5, 1 and 0, and bit 4 reads 0.
- R3: Writing a 1 to control bit 2 (FSK calibrate) or bit 3 (polling calibrate) while that calibration is idle does three things at that edge: the bit reads 1, the done flag clears, and a start pulse that lasts exactly one cycle appears on the matching start output.
- R4: A done pulse arriving while a calibration runs does three things at that edge: the request bit returns to 0, status bit 0 (FSK) or bit 1 (polling) becomes 1, and the flag stays 1 until the next start. A done pulse for an idle calibration has no effect.
- R5: Writing 1 to a calibrate bit that is already 1 issues no new start pulse. Writing 0 to a running calibrate bit does not cancel it.
- R6: Address 0x1A returns status in this layout:
  - bit 7: PLL lock input;
  - bit 6: high-gain input;
  - bit 5: clock-alive input;
  - bits 4..2: always 0;
  - bit 1: polling done flag;
  - bit 0: FSK done flag.
- R7: Writes to 0x1A or to any unmapped address change no register.
- R8: `sleep_o` is 1 whenever control bit 0 is 1 or `enable_pin` is 0.
- R9: `tx_o` is 1 whenever mode bit 6 is 1 or `tr_pin` is 1. Receive (`tx_o`=0) requires both to be 0.
- R10: Automatic FSK calibration starts at a clock edge when all of the following hold:
  - timing bit 6 (auto calibrate) and mode bit 4 (discontinuous receive) are both 1;
  - `sleep_o` was 1 at the previous edge and is 0 now.

  It behaves exactly as a written FSK request.
- R11: When a done pulse and a write of 1 to the same running calibrate bit fall in one cycle, the calibration completes (bit 0, flag 1) and is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| enable_pin | input | 1 | External enable pin |
| tr_pin | input | 1 | External transmit/receive pin |
| pll_lock_i | input | 1 | PLL locked |
| gain_hi_i | input | 1 | LNA in high-gain state |
| clk_alive_i | input | 1 | Valid crystal clock seen |
| fcal_done_i | input | 1 | FSK calibration engine done pulse |
| pcal_done_i | input | 1 | Polling calibration engine done pulse |
| fcal_start_o | output | 1 | FSK calibration start pulse |
| pcal_start_o | output | 1 | Polling calibration start pulse |
| sleep_o | output | 1 | Effective deep-sleep control |
| tx_o | output | 1 | Effective transmit select |
| pwr_o | output | 8 | Power configuration register |
| ctrl_o | output | 8 | Control register view |
| cfg0_o | output | 8 | Mode configuration register |
| cfg1_o | output | 8 | Timing configuration register |

## Verification
An engine's done pulse can land in the same cycle as a host write to the same calibrate bit. An automatic FSK request can also coincide with a written one. The bench provokes both cases. First it runs a directed case: a write of 1 issued together with the done pulse on an already running FSK calibration, which must leave the bit at 0, the flag at 1 and no start pulse. Long random runs then keep done pulses, control writes and enable-pin toggles active together. A behavioural model judges every clock, and it applies the rule that a request is honoured only when the calibration is idle.

// File: rtl/xrb_pkg.sv
package xrb_pkg;

    localparam int unsigned DW = 8;

    localparam int unsigned ADR_PWR  = 'h00;
    localparam int unsigned ADR_CTRL = 'h01;
    localparam int unsigned ADR_CFG0 = 'h02;
    localparam int unsigned ADR_CFG1 = 'h03;
    localparam int unsigned ADR_STAT = 'h1A;

    localparam int unsigned CTRL_SLEEP = 0;
    localparam int unsigned CTRL_FCAL  = 2;
    localparam int unsigned CTRL_PCAL  = 3;
    localparam int unsigned CFG0_DRX   = 4;
    localparam int unsigned CFG0_TX    = 6;
    localparam int unsigned CFG1_ACAL  = 6;

    localparam logic [DW-1:0] PWR_MASK  = 8'hFE;
    localparam logic [DW-1:0] CTRL_MASK = 8'hE3;
    localparam logic [DW-1:0] CFG0_MASK = 8'hFF;
    localparam logic [DW-1:0] CFG1_MASK = 8'h7F;

    localparam int unsigned NUM_CAL  = 2;
    localparam int unsigned CAL_FSK  = 0;
    localparam int unsigned CAL_POLL = 1;

    typedef struct packed {
        logic busy;
        logic flag;
        logic start;
    } cal_state_t;

    typedef struct packed {
        logic [DW-1:0] pwr;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] cfg0;
        logic [DW-1:0] cfg1;
        logic          slp_prev;
    } bank_t;

endpackage

// File: rtl/xrb_cal_slot.sv
module xrb_cal_slot
    import xrb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    output logic busy_o,
    output logic flag_o,
    output logic start_o
);

    cal_state_t cal_d, cal_q;

    always_comb begin
        cal_d       = cal_q;
        cal_d.start = 1'b0;
        if (req_i && !cal_q.busy) begin
            cal_d.busy  = 1'b1;
            cal_d.flag  = 1'b0;
            cal_d.start = 1'b1;
        end else if (cal_q.busy && done_i) begin
            cal_d.busy = 1'b0;
            cal_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    assign busy_o  = cal_q.busy;
    assign flag_o  = cal_q.flag;
    assign start_o = cal_q.start;

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (busy_o && !flag_o));

    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> (!busy_o && flag_o && !start_o));

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> !start_o);

    // R4
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !req_i && done_i) |=> ($stable(flag_o) && !busy_o));

endmodule

// File: rtl/xrb_rd_mux.sv
module xrb_rd_mux
    import xrb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     pwr_i,
    input  logic [DW-1:0]     ctrl_i,
    input  logic [DW-1:0]     cfg0_i,
    input  logic [DW-1:0]     cfg1_i,
    input  logic [DW-1:0]     stat_i,
    output logic [DW-1:0]     rdata_o
);

    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(ADR_PWR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(ADR_CFG0);
    localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(ADR_CFG1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

    always_comb begin
        rdata_o = '0;
        if      (addr_i == A_PWR)  rdata_o = pwr_i;
        else if (addr_i == A_CTRL) rdata_o = ctrl_i;
        else if (addr_i == A_CFG0) rdata_o = cfg0_i;
        else if (addr_i == A_CFG1) rdata_o = cfg1_i;
        else if (addr_i == A_STAT) rdata_o = stat_i;
    end

endmodule

// File: rtl/xcvr_regbank.sv
module xcvr_regbank
    import xrb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              enable_pin,
    input  logic              tr_pin,
    input  logic              pll_lock_i,
    input  logic              gain_hi_i,
    input  logic              clk_alive_i,
    input  logic              fcal_done_i,
    input  logic              pcal_done_i,
    output logic              fcal_start_o,
    output logic              pcal_start_o,
    output logic              sleep_o,
    output logic              tx_o,
    output logic [7:0]        pwr_o,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        cfg0_o,
    output logic [7:0]        cfg1_o
);

    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(ADR_PWR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(ADR_CFG0);
    localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(ADR_CFG1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

    bank_t st_d, st_q;

    logic [NUM_CAL-1:0] cal_req;
    logic [NUM_CAL-1:0] cal_done;
    logic [NUM_CAL-1:0] cal_busy;
    logic [NUM_CAL-1:0] cal_flag;
    logic [NUM_CAL-1:0] cal_start;
    logic               sleep_now;
    logic               auto_req;
    logic               ctrl_wr;
    logic [DW-1:0]      ctrl_view;
    logic [DW-1:0]      stat_view;

    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign sleep_now = st_q.ctrl[CTRL_SLEEP] | ~enable_pin;
    assign auto_req  = st_q.cfg1[CFG1_ACAL] & st_q.cfg0[CFG0_DRX]
                     & st_q.slp_prev & ~sleep_now;

    always_comb begin
        st_d          = st_q;
        st_d.slp_prev = sleep_now;
        if (wr_en) begin
            if      (addr == A_PWR)  st_d.pwr  = wdata & PWR_MASK;
            else if (addr == A_CTRL) st_d.ctrl = wdata & CTRL_MASK;
            else if (addr == A_CFG0) st_d.cfg0 = wdata & CFG0_MASK;
            else if (addr == A_CFG1) st_d.cfg1 = wdata & CFG1_MASK;
        end
        cal_req[CAL_FSK]  = (ctrl_wr && wdata[CTRL_FCAL]) || auto_req;
        cal_req[CAL_POLL] = ctrl_wr && wdata[CTRL_PCAL];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cal_done[CAL_FSK]  = fcal_done_i;
    assign cal_done[CAL_POLL] = pcal_done_i;

    for (genvar gi = 0; gi < NUM_CAL; gi++) begin : g_cal
        xrb_cal_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (cal_req[gi]),
            .done_i  (cal_done[gi]),
            .busy_o  (cal_busy[gi]),
            .flag_o  (cal_flag[gi]),
            .start_o (cal_start[gi])
        );
    end

    always_comb begin
        ctrl_view            = st_q.ctrl;
        ctrl_view[CTRL_FCAL] = cal_busy[CAL_FSK];
        ctrl_view[CTRL_PCAL] = cal_busy[CAL_POLL];
        stat_view            = {pll_lock_i, gain_hi_i, clk_alive_i, 3'b000,
                                cal_flag[CAL_POLL], cal_flag[CAL_FSK]};
    end

    xrb_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .addr_i  (addr),
        .pwr_i   (st_q.pwr),
        .ctrl_i  (ctrl_view),
        .cfg0_i  (st_q.cfg0),
        .cfg1_i  (st_q.cfg1),
        .stat_i  (stat_view),
        .rdata_o (rdata)
    );

    assign fcal_start_o = cal_start[CAL_FSK];
    assign pcal_start_o = cal_start[CAL_POLL];
    assign sleep_o      = sleep_now;
    assign tx_o         = st_q.cfg0[CFG0_TX] | tr_pin;
    assign pwr_o        = st_q.pwr;
    assign ctrl_o       = ctrl_view;
    assign cfg0_o       = st_q.cfg0;
    assign cfg1_o       = st_q.cfg1;

    // R8
    sleep_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_pin |-> sleep_o);

    // R9
    tx_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_pin |-> tx_o);

    // R7
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT) |=>
        ($stable(pwr_o) && $stable(cfg0_o) && $stable(cfg1_o)));

    // R10
    auto_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg1_o[CFG1_ACAL] && cfg0_o[CFG0_DRX] && $fell(sleep_o) && !ctrl_o[CTRL_FCAL])
        |=> fcal_start_o);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_o[0] && !ctrl_o[4] && !cfg1_o[7]);

endmodule

// File: tb/xcvr_regbank_bench.sv
module xcvr_regbank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       enable_pin = 1'b1;
    logic       tr_pin = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic       gain_hi_i = 1'b0;
    logic       clk_alive_i = 1'b0;
    logic       fcal_done_i = 1'b0;
    logic       pcal_done_i = 1'b0;
    logic [7:0] rdata, pwr_o, ctrl_o, cfg0_o, cfg1_o;
    logic       fcal_start_o, pcal_start_o, sleep_o, tx_o;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 0;

    always #4 clk = ~clk;

    xcvr_regbank #(.ADDR_W(8)) u_xcvr_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .enable_pin(enable_pin), .tr_pin(tr_pin),
        .pll_lock_i(pll_lock_i), .gain_hi_i(gain_hi_i), .clk_alive_i(clk_alive_i),
        .fcal_done_i(fcal_done_i), .pcal_done_i(pcal_done_i),
        .fcal_start_o(fcal_start_o), .pcal_start_o(pcal_start_o),
        .sleep_o(sleep_o), .tx_o(tx_o), .pwr_o(pwr_o), .ctrl_o(ctrl_o),
        .cfg0_o(cfg0_o), .cfg1_o(cfg1_o)
    );

    // behavioural reference
    int m_pwr, m_ctrl, m_cfg0, m_cfg1;
    int m_fbusy, m_pbusy, m_fflag, m_pflag, m_fstart, m_pstart, m_slp_prev;

    function automatic int m_sleep();
        return ((m_ctrl & 1) != 0 || !enable_pin) ? 1 : 0;
    endfunction

    function automatic int m_ctrl_view();
        return m_ctrl | (m_fbusy << 2) | (m_pbusy << 3);
    endfunction

    function automatic int m_rdata();
        case (addr)
            8'h00: return m_pwr;
            8'h01: return m_ctrl_view();
            8'h02: return m_cfg0;
            8'h03: return m_cfg1;
            8'h1A: return (pll_lock_i << 7) | (gain_hi_i << 6) | (clk_alive_i << 5)
                        | (m_pflag << 1) | m_fflag;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pwr = 0; m_ctrl = 0; m_cfg0 = 0; m_cfg1 = 0;
            m_fbusy = 0; m_pbusy = 0; m_fflag = 0; m_pflag = 0;
            m_fstart = 0; m_pstart = 0; m_slp_prev = 0;
        end else begin
            int slp, autoq, freq, preq;
            slp   = m_sleep();
            autoq = (((m_cfg1 >> 6) & 1) != 0 && ((m_cfg0 >> 4) & 1) != 0
                     && m_slp_prev != 0 && slp == 0) ? 1 : 0;
            freq  = ((wr_en && addr == 8'h01 && wdata[2]) || autoq != 0) ? 1 : 0;
            preq  = (wr_en && addr == 8'h01 && wdata[3]) ? 1 : 0;
            m_fstart = 0; m_pstart = 0;
            if (freq != 0 && m_fbusy == 0) begin m_fbusy = 1; m_fflag = 0; m_fstart = 1; end
            else if (m_fbusy != 0 && fcal_done_i) begin m_fbusy = 0; m_fflag = 1; end
            if (preq != 0 && m_pbusy == 0) begin m_pbusy = 1; m_pflag = 0; m_pstart = 1; end
            else if (m_pbusy != 0 && pcal_done_i) begin m_pbusy = 0; m_pflag = 1; end
            if (wr_en) begin
                case (addr)
                    8'h00: m_pwr  = wdata & 8'hFE;
                    8'h01: m_ctrl = wdata & 8'hE3;
                    8'h02: m_cfg0 = wdata;
                    8'h03: m_cfg1 = wdata & 8'h7F;
                    default: ;
                endcase
            end
            m_slp_prev = slp;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rtag;
        rtag = (addr == 8'h1A) ? "R6 status read" :
               (addr == 8'h01) ? "R3/R4/R5 ctrl read" : "R2/R7 reg read";
        chk(rtag, rdata, m_rdata());
        chk("R8 sleep_o", sleep_o, m_sleep());
        chk("R9 tx_o", tx_o, (((m_cfg0 >> 6) & 1) != 0 || tr_pin) ? 1 : 0);
        chk("R3 R10 fcal_start_o", fcal_start_o, m_fstart);
        chk("R3 pcal_start_o", pcal_start_o, m_pstart);
        chk("R2 pwr_o", pwr_o, m_pwr);
        chk("R5 ctrl_o", ctrl_o, m_ctrl_view());
        chk("R2 cfg0_o", cfg0_o, m_cfg0);
        chk("R2 cfg1_o", cfg1_o, m_cfg1);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        compare_all();
    endtask

    task automatic idle_in();
        wr_en = 0; fcal_done_i = 0; pcal_done_i = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1 pwr", pwr_o, 0);
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 cfg0", cfg0_o, 0);
        chk("R1 cfg1", cfg1_o, 0);
        addr = 8'h1A; #1;
        chk("R1 status flags", rdata, 0);
        chk("R1 no start", fcal_start_o | pcal_start_o, 0);

        // R3: start FSK calibration
        wr_en = 1; addr = 8'h01; wdata = 8'h04; step();
        idle_in(); addr = 8'h01;
        chk("R3 fcal pulse", fcal_start_o, 1);
        step();
        chk("R3 pulse one cycle", fcal_start_o, 0);
        // R11: write 1 together with done on the running FSK calibration
        wr_en = 1; addr = 8'h01; wdata = 8'h04; fcal_done_i = 1; step();
        idle_in(); addr = 8'h1A;
        #1 chk("R11 flag set, no restart", rdata[0], 1);
        chk("R11 bit cleared", ctrl_o[2], 0);
        step();
        chk("R11 no start pulse", fcal_start_o, 0);

        // R7: write to status address
        wr_en = 1; addr = 8'h1A; wdata = 8'hFF; step();
        idle_in();
        chk("R7 status write ignored", pwr_o | cfg0_o | cfg1_o | ctrl_o, 0);

        // R10: automatic calibration on sleep exit
        wr_en = 1; addr = 8'h02; wdata = 8'h10; step();
        wr_en = 1; addr = 8'h03; wdata = 8'h40; step();
        idle_in(); enable_pin = 0; step();
        enable_pin = 1; step();
        chk("R10 auto start", fcal_start_o, 1);
        fcal_done_i = 1; step();
        idle_in();

        // random traffic with coinciding done pulses and pin toggles
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel   = $urandom_range(0, 6);
            wr_en = ($urandom_range(0, 2) == 0);
            case (sel)
                0: addr = 8'h00; 1: addr = 8'h01; 2: addr = 8'h01;
                3: addr = 8'h02; 4: addr = 8'h03; 5: addr = 8'h1A;
                default: addr = 8'($urandom_range(4, 255));
            endcase
            wdata       = 8'($urandom);
            if (addr == 8'h01) wdata[0] = ($urandom_range(0, 3) == 0);
            fcal_done_i = ($urandom_range(0, 4) == 0);
            pcal_done_i = ($urandom_range(0, 4) == 0);
            enable_pin  = ($urandom_range(0, 3) != 0);
            tr_pin      = ($urandom_range(0, 3) == 0);
            pll_lock_i  = 1'($urandom);
            gain_hi_i   = 1'($urandom);
            clk_alive_i = 1'($urandom);
            step();
        end
        idle_in();
        step();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule